// File: doc/BRIEF.md
# Delayed Completion Interrupt Coalescer

This block sits beside a descriptor-driven copy engine and turns a stream of per-descriptor completion pulses into one level-sensitive interrupt. It does not interrupt on every completion. It counts the completions that are still unacknowledged and runs a coarse timer from the first of them. It raises a single sticky status bit when either the count or the elapsed time goes past a programmed limit, whichever happens first. Software reads the status, writes the value back to acknowledge it, and the count and the timer start again from zero.

The time base is a prescaler on the core clock. It produces one tick per 20 microsecond unit, and the number of core clocks per unit is a parameter. The prescaler and the timer run only while at least one completion is pending, so idle periods do not count towards the timeout. When coalescing is turned off in the configuration register, every completion pulse sets the status bit straight away. An enable mask gates the output line and leaves the status untouched.

A small register port gives access to three word registers: configuration, status and enable mask. Reads return data one cycle after the request.

Top module: `coal_irq_top`

## Requirements
- R1: After reset the configuration register (byte offset 0x00) reads 0x0001_1414, which means coalescing on with a count limit of 20 and a time limit of 20. The status register (offset 0x04) reads 0, the enable register (offset 0x08) reads 0, and irq_o is low. A read returns its data on reg_rdata_o with reg_rvalid_o high, one cycle after reg_rd_i is sampled.
- R2: Configuration bits 6:0 hold the count limit. With coalescing on, status bit 0 sets when the number of pending completions exceeds the count limit. irq_o rises on the second rising edge after the completion that crosses the limit is sampled. This holds at both ends of the field: limit 0 fires on the first completion, and limit 127 fires on the 128th. The pending count saturates and does not wrap.
- R3: Configuration bits 14:8 hold the time limit, in ticks of TICK_CLKS core clocks. With coalescing on, the status sets once the number of ticks elapsed since the first pending completion exceeds the time limit. irq_o rises (limit+1)*TICK_CLKS+1 edges after the edge that samples that first completion.
- R4: Configuration bit 16 switches coalescing on or off. With it at 0, each done_i pulse sets the status bit at the edge that samples the pulse.
- R5: Writing a word with bit 0 set to the status register clears the status bit. A write with bit 0 at 0 leaves it unchanged.
- R6: Clearing the status also empties the pending count and resets the timer, so a fresh set of completions past the limit is needed before the next interrupt.
- R7: irq_o is status bit 0 gated by enable register bit 0. Clearing the enable bit drops irq_o and keeps the status bit set and readable.
- R8: A done_i pulse in the same cycle as a status clear is not lost. The status clears, and that pulse becomes the first pending completion of the new window.
- R9: The timer advances only while a completion is pending. Idle time before a completion does not shorten its timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| done_i | input | 1 | One-cycle pulse per completed receive descriptor |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_rd_i |
| irq_o | output | 1 | Level completion interrupt |

## Verification
The two functions that can fall in the same cycle are a completion pulse and the software acknowledge, which clears the status and restarts the window. The bench drives done_i and a status write carrying bit 0 on the same clock, with the count limit at 0. It then expects irq_o to drop at that edge and rise again one edge later. That second rise shows the coincident pulse was kept as the first pending completion. A plain acknowledge with no pulse is run next to it, and irq_o must stay low there.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int FIELD_W      = 7;
  localparam int CTR_W        = FIELD_W + 1;
  localparam int DATA_W       = 32;
  localparam int OFF_CFG      = 'h00;
  localparam int OFF_STAT     = 'h04;
  localparam int OFF_MASK     = 'h08;
  localparam int CFG_CNT_LSB  = 0;
  localparam int CFG_TIME_LSB = 8;
  localparam int CFG_EN_BIT   = 16;
  localparam int STAT_BIT     = 0;
  localparam int MASK_BIT     = 0;
  localparam int DEF_CNT      = 20;
  localparam int DEF_TIME     = 20;

  typedef struct packed {
    logic               coal_en;
    logic [FIELD_W-1:0] max_time;
    logic [FIELD_W-1:0] max_cnt;
  } coal_cfg_t;
endpackage

// File: rtl/coal_rst_sync.sv
module coal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/coal_tick_gen.sv
module coal_tick_gen #(
  parameter int TICK_CLKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (TICK_CLKS <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      localparam int PW = $clog2(TICK_CLKS);
      localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);
      logic [PW-1:0] pre_q, pre_n;

      always_comb begin
        if (!run_i)             pre_n = '0;
        else if (pre_q == LAST) pre_n = '0;
        else                    pre_n = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_n;
      end

      assign tick_o = run_i && (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/coal_sat_ctr.sv
module coal_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_one_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (clr_i)                       cnt_n = W'(load_one_i);
    else if (inc_i && cnt_q != TOP)  cnt_n = cnt_q + 1'b1;
    else                             cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coal_regs.sv
module coal_regs
  import coal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fire_i,
  input  logic              imm_i,
  output coal_cfg_t         cfg_o,
  output logic              mask_o,
  output logic              status_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

  coal_cfg_t         cfg_q, cfg_n;
  logic              mask_q, mask_n;
  logic              stat_q, stat_n;
  logic [DATA_W-1:0] rdata_q, rdata_n, rd_word;
  logic              rvalid_q;

  always_comb begin
    clr_o  = wr_i && (addr_i == A_STAT) && wdata_i[STAT_BIT];
    cfg_n  = cfg_q;
    mask_n = mask_q;
    if (wr_i && addr_i == A_CFG) begin
      cfg_n.coal_en  = wdata_i[CFG_EN_BIT];
      cfg_n.max_time = wdata_i[CFG_TIME_LSB +: FIELD_W];
      cfg_n.max_cnt  = wdata_i[CFG_CNT_LSB +: FIELD_W];
    end
    if (wr_i && addr_i == A_MASK) mask_n = wdata_i[MASK_BIT];
    stat_n = clr_o ? imm_i : (stat_q | fire_i | imm_i);

    rd_word = '0;
    case (addr_i)
      A_CFG: begin
        rd_word[CFG_EN_BIT]                  = cfg_q.coal_en;
        rd_word[CFG_TIME_LSB +: FIELD_W]     = cfg_q.max_time;
        rd_word[CFG_CNT_LSB +: FIELD_W]      = cfg_q.max_cnt;
      end
      A_STAT:  rd_word[STAT_BIT] = stat_q;
      A_MASK:  rd_word[MASK_BIT] = mask_q;
      default: rd_word = '0;
    endcase
    rdata_n = rd_i ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.coal_en  <= 1'b1;
      cfg_q.max_time <= FIELD_W'(DEF_TIME);
      cfg_q.max_cnt  <= FIELD_W'(DEF_CNT);
      mask_q         <= 1'b0;
      stat_q         <= 1'b0;
      rdata_q        <= '0;
      rvalid_q       <= 1'b0;
    end else begin
      cfg_q    <= cfg_n;
      mask_q   <= mask_n;
      stat_q   <= stat_n;
      rdata_q  <= rdata_n;
      rvalid_q <= rd_i;
    end
  end

  assign cfg_o    = cfg_q;
  assign mask_o   = mask_q;
  assign status_o = stat_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/coal_irq_top.sv
module coal_irq_top
  import coal_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int TICK_CLKS = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              irq_o
);
  logic             rst_sync_n;
  coal_cfg_t        cfg;
  logic             mask, status, clr, fire, imm, tick, run;
  logic [CTR_W-1:0] pend_cnt, time_cnt;

  coal_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign run = (pend_cnt != '0) && !clr;

  coal_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .run_i(run), .tick_o(tick)
  );

  coal_sat_ctr #(.W(CTR_W)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(clr), .load_one_i(done_i),
    .inc_i(done_i), .cnt_o(pend_cnt)
  );

  coal_sat_ctr #(.W(CTR_W)) u_time (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(clr), .load_one_i(1'b0),
    .inc_i(tick), .cnt_o(time_cnt)
  );

  always_comb begin
    imm  = !cfg.coal_en && done_i;
    fire = cfg.coal_en &&
           ((pend_cnt > {1'b0, cfg.max_cnt}) || (time_cnt > {1'b0, cfg.max_time}));
  end

  coal_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .fire_i(fire), .imm_i(imm),
    .cfg_o(cfg), .mask_o(mask), .status_o(status), .clr_o(clr),
    .rdata_o(reg_rdata_o), .rvalid_o(reg_rvalid_o)
  );

  assign irq_o = status && mask;
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          clr,
  input logic          coal_en,
  input logic          mask,
  input logic          status,
  input logic [CW-1:0] pend_cnt,
  input logic [CW-1:0] time_cnt
);
  localparam logic [CW-1:0] TOP = '1;

  // R2: saturating pending count
  assert_pend_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == TOP && done && !clr) |=> pend_cnt == TOP);

  // R4: bypass mode sets status at once
  assert_bypass_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!coal_en && done) |=> status);

  // R5: acknowledge clears status unless bypass pulse coincides
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(done && !coal_en)) |=> !status);

  // R7: masking never loses a set status
  assert_mask_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !mask && !clr) |=> status);

  // R8: coincident pulse seeds the new window
  assert_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && done) |=> pend_cnt == CW'(1));

  // R9: timer idle while nothing pending
  assert_timer_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0) |-> time_cnt == '0);
endmodule

bind coal_irq_top coal_chk #(.CW(coal_pkg::CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .done(done_i), .clr(clr),
  .coal_en(cfg.coal_en), .mask(mask), .status(status),
  .pend_cnt(pend_cnt), .time_cnt(time_cnt)
);

// File: tb/coal_irq_top_tb_top.sv
module coal_irq_top_tb_top;
  localparam int AW   = 8;
  localparam int TICK = 4;
  localparam logic [AW-1:0] A_CFG = 8'h00, A_STAT = 8'h04, A_MASK = 8'h08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct { logic [31:0] exp; string req; } rd_item_t;
  rd_item_t sb_q[$];

  always #4 clk = ~clk;

  coal_irq_top #(.ADDR_W(AW), .TICK_CLKS(TICK)) dut_i (
    .clk(clk), .rst_n(rst_n), .done_i(done), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .reg_rvalid_o(rvalid), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rvalid) begin
      if (sb_q.size() == 0) chk("R1 unexpected rvalid", 32'd1, 32'd0);
      else begin
        rd_item_t it;
        it = sb_q.pop_front();
        chk(it.req, rdata, it.exp);
      end
    end
  end

  function automatic logic [31:0] cfgw(input logic en, input int cnt, input int tim);
    return {15'd0, en, 1'b0, 7'(tim), 1'b0, 7'(cnt)};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, input logic [31:0] e, input string req);
    rd_item_t it;
    @(negedge clk); rd = 1'b1; addr = a;
    it.exp = e; it.req = req; sb_q.push_back(it);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'd0);
    reg_rd(A_CFG, 32'h0001_1414, "R1 cfg reset");
    reg_rd(A_STAT, 32'd0, "R1 status reset");
    reg_rd(A_MASK, 32'd0, "R1 mask reset");

    // R2 count path, limit 2
    reg_wr(A_MASK, 32'd1);
    reg_wr(A_CFG, cfgw(1'b1, 2, 127));
    reg_rd(A_CFG, cfgw(1'b1, 2, 127), "R2 cfg readback");
    pulse(); pulse(); step(3);
    chk("R2 no irq at limit", 32'(irq), 32'd0);
    pulse();
    chk("R2 irq one edge early", 32'(irq), 32'd0);
    step(1);
    chk("R2 irq over limit", 32'(irq), 32'd1);
    reg_rd(A_STAT, 32'd1, "R2 status set");

    // R5 write-one-to-clear
    reg_wr(A_STAT, 32'd0);
    chk("R5 zero write keeps", 32'(irq), 32'd1);
    reg_wr(A_STAT, 32'd1);
    chk("R5 one write clears", 32'(irq), 32'd0);
    reg_rd(A_STAT, 32'd0, "R5 status cleared");

    // R6 fresh window after clear
    pulse(); pulse(); step(2);
    chk("R6 count restarted", 32'(irq), 32'd0);
    pulse(); step(1);
    chk("R6 fires after fresh window", 32'(irq), 32'd1);

    // R7 mask
    reg_wr(A_MASK, 32'd0);
    chk("R7 masked irq low", 32'(irq), 32'd0);
    reg_rd(A_STAT, 32'd1, "R7 status kept under mask");
    reg_wr(A_MASK, 32'd1);
    chk("R7 unmask irq high", 32'(irq), 32'd1);
    reg_wr(A_STAT, 32'd1);

    // R3 timeout path, limit 3 ticks
    reg_wr(A_CFG, cfgw(1'b1, 127, 3));
    pulse(); step(4 * TICK);
    chk("R3 before timeout", 32'(irq), 32'd0);
    step(1);
    chk("R3 at timeout", 32'(irq), 32'd1);
    reg_wr(A_STAT, 32'd1);

    // R9 idle time does not count
    step(100);
    chk("R9 idle no irq", 32'(irq), 32'd0);
    pulse(); step(4 * TICK);
    chk("R9 full timeout still pending", 32'(irq), 32'd0);
    step(1);
    chk("R9 timeout after idle", 32'(irq), 32'd1);
    reg_wr(A_STAT, 32'd1);

    // R4 coalescing off
    reg_wr(A_CFG, cfgw(1'b0, 127, 127));
    pulse();
    chk("R4 immediate set", 32'(irq), 32'd1);
    reg_wr(A_STAT, 32'd1);
    step(20);
    chk("R4 stays clear", 32'(irq), 32'd0);

    // R8 collision of pulse and acknowledge, limit 0
    reg_wr(A_CFG, cfgw(1'b1, 0, 127));
    pulse(); step(1);
    chk("R2 limit zero fires", 32'(irq), 32'd1);
    @(negedge clk); done = 1'b1; wr = 1'b1; addr = A_STAT; wdata = 32'd1;
    @(negedge clk); done = 1'b0; wr = 1'b0;
    chk("R8 cleared at collision", 32'(irq), 32'd0);
    step(1);
    chk("R8 pulse kept", 32'(irq), 32'd1);
    reg_wr(A_STAT, 32'd1);
    step(3);
    chk("R8 plain clear stays low", 32'(irq), 32'd0);

    // R2 upper boundary, limit 127
    reg_wr(A_CFG, cfgw(1'b1, 127, 127));
    repeat (127) pulse();
    step(1);
    chk("R2 127 pending no irq", 32'(irq), 32'd0);
    pulse(); step(1);
    chk("R2 128th fires", 32'(irq), 32'd1);
    reg_wr(A_STAT, 32'd1);

    step(3);
    chk("R1 all reads returned", 32'(sb_q.size()), 32'd0);
    finish_run();
  end
endmodule